// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data, open-drain). It stands in for a small byte-wide EEPROM. Storage is an internal register array of one or more 256-byte page blocks. Both bus lines are sampled with the system clock. The block detects START and STOP conditions and shifts in a slave address byte, whose device-type code and device field it checks against strap inputs. It then takes an array address followed by write data, or it returns read data. SDA is driven only by pulling it low: `sda_oe` high means the pad pulls SDA to 0.

The 3-bit device field in the address byte has two jobs. Its low `log2(NUM_BLOCKS)` bits pick a 256-byte page block inside this device. Its remaining high bits must equal the matching strap pins. Strap pins whose position is used for block selection are ignored. The block supports byte write, 16-byte page write, current-address read and sequential read. There is no programming delay, no write protect and no clock stretching. The pins are plain control lines and carry no handshake. The bus master is the only source of pacing.

Top module: `eeprom2w_slave`

## Requirements
- R1: SDA falling while SCL is high is a START. From any state it restarts decoding with a fresh slave address byte. SDA rising while SCL is high is a STOP. It returns the block to idle with `sda_oe` low, and any byte in progress is abandoned without a write.
- R2: The address byte is shifted in MSB first on SCL rising edges. Bits 7:4 must be 4'b1010. Bits 3:1 are the device field. Bit 0 selects read (1) or write (0).
- R3: For every accepted received byte, `sda_oe` goes high after the SCL falling edge that ends the 8th bit. It stays high through the 9th clock and drops after the SCL falling edge that ends the 9th clock.
- R4: If the device type or the compared strap bits mismatch, the address byte is not acknowledged. The block then ignores the bus (no acknowledge, no write, `sda_oe` low) until the next START.
- R5: With NUM_BLOCKS = 2^k, device-field bits k-1:0 select the page block and the upper 3-k bits are compared with `strap_sel[2:k]`. The lower strap pins have no effect.
- R6: In a write, the byte after the address byte is loaded as the array address. Each following data byte is acknowledged and stored at the current address of the selected block.
- R7: After each stored data byte, address bits 3:0 increment and wrap within the 16-byte page. Bits 7:4 stay unchanged.
- R8: A read returns data MSB first. SDA changes only while SCL is low. The first byte comes from the internal address counter, which holds the last accessed address plus one (page-wrapped after a write).
- R9: During a read, a master acknowledge (SDA low in the 9th clock) makes the block send the next byte, with the counter wrapping from 0xFF to 0x00 inside the same block. A master non-acknowledge makes the block release SDA and stay quiet until the next START.
- R10: A repeated START after a write address makes the next read begin at the address counter. This gives a random read.
- R11: After reset, `sda_oe` is low, the address counter is 0 and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_sel | input | 3 | Device select strap pins for device-field bits 3:1 |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench writes pages starting mid-page so the 16-byte wrap is crossed. A design that carried into bits 7:4 would scatter bytes into the next page, and readback would show it. Sequential reads run past 0xFF in each block. An increment that spilled into the block index, or stopped at the end, would return the other block's bytes. Address bytes that mismatch in type or in a compared strap bit are followed by address and data bytes. A block that woke up mid-transfer would acknowledge them or alter the array. A toggle on an ignored strap pin must not change selection. A repeated START and a STOP inside a byte expose a bit counter that is not cleared, or a write committed too early.

// File: rtl/e2w_pkg.sv
package e2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WR,
    ST_RD
  } e2w_state_t;

  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;
  localparam int BYTE_BITS  = 8;
  localparam int PAGE_BITS  = 4;
endpackage

// File: rtl/e2w_line_sense.sv
module e2w_line_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign scl_rise  = ~scl_d & scl_s;
  assign scl_fall  = scl_d & ~scl_s;
  assign start_det = scl_d & scl_s & sda_d & ~sda_s;
  assign stop_det  = scl_d & scl_s & ~sda_d & sda_s;
endmodule

// File: rtl/e2w_store.sv
module e2w_store #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
  import e2w_pkg::*;
#(
  parameter int NUM_BLOCKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_sel,
  output logic       sda_oe
);
  localparam int         BLK_BITS = $clog2(NUM_BLOCKS);
  localparam int         AW       = BYTE_BITS + BLK_BITS;
  localparam logic [2:0] SEL_MASK = 3'(3'b111 << BLK_BITS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  e2w_line_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  e2w_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, ptr;
  logic [2:0] blk_sel;
  logic       rw_q, m_ack;

  logic        dev_hit, wr_en;
  logic [10:0] full_addr;
  logic [7:0]  rd_byte;

  assign dev_hit   = (rx_sh[7:4] == DEV_TYPE_CODE) &&
                     (((rx_sh[3:1] ^ strap_sel) & SEL_MASK) == 3'b000);
  assign full_addr = {blk_sel & ~SEL_MASK, ptr};
  assign wr_en     = scl_fall && (bit_cnt == 4'd8) && (state == ST_WR);

  e2w_store #(.AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(full_addr[AW-1:0]),
    .wdata(rx_sh), .rdata(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      blk_sel <= '0;
      rw_q    <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt < 4'd8) begin
          rx_sh   <= {rx_sh[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
          m_ack   <= ~sda_s;
        end
      end else if (scl_fall) begin
        if (bit_cnt == 4'd8) begin
          unique case (state)
            ST_DEV: begin
              if (dev_hit) begin
                sda_oe  <= 1'b1;
                rw_q    <= rx_sh[0];
                blk_sel <= rx_sh[3:1];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              ptr    <= rx_sh;
              sda_oe <= 1'b1;
            end
            ST_WR: begin
              ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 4'd1;
              sda_oe <= 1'b1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (bit_cnt == 4'd9) begin
          bit_cnt <= '0;
          sda_oe  <= 1'b0;
          unique case (state)
            ST_DEV:  state <= rw_q ? ST_RD : ST_ADDR;
            ST_ADDR: state <= ST_WR;
            ST_WR:   state <= ST_WR;
            default: if (!m_ack) state <= ST_IDLE;
          endcase
          if ((state == ST_DEV && rw_q) || (state == ST_RD && m_ack)) begin
            tx_sh  <= rd_byte;
            sda_oe <= ~rd_byte[7];
            ptr    <= ptr + 8'd1;
          end
        end else if (state == ST_RD && bit_cnt != 4'd0) begin
          tx_sh  <= {tx_sh[6:0], 1'b0};
          sda_oe <= ~tx_sh[6];
        end
      end
    end
  end

  // R3
  ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == 4'd9 && (state == ST_DEV || state == ST_ADDR || state == ST_WR)) |-> sda_oe);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R8
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R7
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr[7:4] == $past(ptr[7:4])) && (ptr[3:0] == $past(ptr[3:0]) + 4'd1));

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && scl_fall && bit_cnt == 4'd9 && !m_ack && !start_det && !stop_det)
      |=> (state == ST_IDLE) && !sda_oe);
endmodule

// File: tb/eeprom2w_slave_tb_top.sv
module eeprom2w_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  logic       sda_oe;
  logic       line;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem_m [512];
  logic [7:0] ptr_m;

  assign line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  eeprom2w_slave #(.NUM_BLOCKS(2), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .strap_sel(strap), .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic bit_slot(input logic b, output logic s);
    sda_m = b; qwait(); scl = 1'b1; qwait(); s = line; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
    bit_slot(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      bit_slot(1'b1, s);
      d = {d[6:0], s};
    end
    bit_slot(~ack, s);
  endtask

  function automatic logic [7:0] dev_byte(input logic b, input logic rw);
    return {4'b1010, 2'b01, b, rw};
  endfunction

  // R6 R7: page write with model update (page-wrapped address)
  task automatic page_write(input logic b, input logic [7:0] a, input int n, input int seed);
    logic ack;
    logic [7:0] p, d;
    bus_start();
    send_byte(dev_byte(b, 1'b0), ack); chk("R2 write address ack", ack, 1);
    send_byte(a, ack);                 chk("R6 array address ack", ack, 1);
    p = a;
    for (int i = 0; i < n; i++) begin
      d = 8'((int'(p) * 7 + seed + int'(b) * 85) & 255);
      send_byte(d, ack); chk("R7 data ack", ack, 1);
      mem_m[{b, p}] = d;
      p = {p[7:4], p[3:0] + 4'd1};
    end
    ptr_m = p;
    bus_stop();
  endtask

  // R8 R9: read n bytes from the counter, NACK on last
  task automatic read_run(input logic b, input int n, input string req);
    logic ack;
    logic [7:0] d;
    send_byte(dev_byte(b, 1'b1), ack); chk("R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(req, d, mem_m[{b, ptr_m}]);
      ptr_m = ptr_m + 8'd1;
    end
    chk("R9 release after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic random_read(input logic b, input logic [7:0] a, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(dev_byte(b, 1'b0), ack); chk("R10 dummy write ack", ack, 1);
    send_byte(a, ack);                 chk("R10 address ack", ack, 1);
    ptr_m = a;
    bus_start();
    read_run(b, n, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic s;
    logic [7:0] d;
    for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
    ptr_m = 8'h00;
    repeat (5) @(negedge clk);
    chk("R11 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: counter at 0 and array cleared
    bus_start();
    read_run(1'b0, 2, "R11 read after reset");

    // R7: page writes, several starting mid-page so the 16-byte wrap occurs
    page_write(1'b0, 8'h00, 16, 3);
    page_write(1'b0, 8'h5A, 16, 11);
    page_write(1'b0, 8'hA3, 16, 29);
    page_write(1'b0, 8'hF8, 16, 41);
    page_write(1'b1, 8'h3C, 16, 53);
    page_write(1'b1, 8'hF0, 16, 67);
    page_write(1'b1, 8'h77, 1, 99);

    // R8: current address read continues from last write + 1
    bus_start();
    read_run(1'b1, 2, "R8 current address read");

    // R9: sequential read of all of block 0 plus wrap past 0xFF
    random_read(1'b0, 8'h00, 258, "R9 sequential block 0");
    random_read(1'b1, 8'hFE, 4, "R9 wrap in block 1");

    // R4: wrong device type, then bytes that must be ignored
    bus_start();
    send_byte(8'hB4, ack); chk("R4 wrong type nack", ack, 0);
    send_byte(8'h10, ack); chk("R4 ignored address", ack, 0);
    send_byte(8'hEE, ack); chk("R4 ignored data", ack, 0);
    chk("R4 quiet line", sda_oe, 0);
    bus_stop();
    // R4: compared strap bit mismatch (field 3'b110)
    bus_start();
    send_byte({4'b1010, 3'b110, 1'b0}, ack); chk("R4 strap mismatch nack", ack, 0);
    send_byte(8'h10, ack); chk("R4 ignored address 2", ack, 0);
    send_byte(8'hEE, ack); chk("R4 ignored data 2", ack, 0);
    bus_stop();
    random_read(1'b0, 8'h10, 1, "R4 array unchanged");

    // R5: ignored strap pin toggled; block bit still selects the block
    strap = 3'b011;
    page_write(1'b0, 8'h20, 1, 150);
    page_write(1'b1, 8'h20, 1, 201);
    strap = 3'b010;
    random_read(1'b0, 8'h20, 1, "R5 block 0 with strap0 toggled");
    random_read(1'b1, 8'h20, 1, "R5 block 1 with strap0 toggled");

    // R10: repeated START right after a data byte
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), ack); chk("R10 write ack", ack, 1);
    send_byte(8'h40, ack);                chk("R10 addr ack", ack, 1);
    send_byte(8'hC3, ack);                chk("R10 data ack", ack, 1);
    mem_m[{1'b0, 8'h40}] = 8'hC3;
    ptr_m = 8'h41;
    bus_start();
    read_run(1'b0, 1, "R10 read after repeated start");

    // R1: STOP in the middle of a data byte abandons it
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), ack); chk("R1 write ack", ack, 1);
    send_byte(8'h50, ack);                chk("R1 addr ack", ack, 1);
    for (int i = 0; i < 4; i++) bit_slot(1'b1, s);
    bus_stop();
    chk("R1 idle after stop", sda_oe, 0);
    random_read(1'b0, 8'h50, 1, "R1 aborted byte not written");

    // R2: read flag on a block-1 byte read right after a block-0 access
    random_read(1'b1, 8'h3C, 3, "R2 read direction");

    d = 8'h00;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule